// File: doc/BRIEF.md
# BCD Calendar Real-Time Counter

This block keeps wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and year. A prescaler counts pulses of a 32768 Hz clock-enable input and emits one tick per second. That tick drives a cascade of field counters. The day counter knows the length of each month. February's length comes from a leap flag that software writes, not from the year value.

Software writes new values into a set of staged registers through a simple write-strobe port. Staged values do nothing until software sets the commit bit in the update register. One cycle later, all seven fields and the leap flag replace the running time in a single step, and the prescaler restarts. A read-address port returns the running time combinationally. A control bit selects between a 24-hour and a 12-hour hour format.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the running time reads seconds 00, minutes 00, hour 00, weekday 0, day 01, month 01, year 00 with the leap flag clear, the control register reads 1 (24-hour format) and the update register reads 0.
- R2: Writes to the seven time addresses change only staged copies; the running value read back at the same address keeps its old value until a commit.
- R3: Writing address 8 with bit 15 set commits all staged fields and the staged leap flag together on the next clock edge. The update register reads 0x8000 for exactly the cycle between the write and the commit, then reads 0.
- R4: The second count advances once for every PRESCALE cycles with `tick_en` high. Nothing advances while `tick_en` is low. A commit restarts the prescaler count from zero.
- R5: Seconds and minutes count in BCD from 00 to 59; 59 wraps to 00 and carries into the next field.
- R6: With control bit 0 set, hours count 00 to 23 in BCD, and 23 wraps to 00 with a carry into day and weekday.
- R7: With control bit 0 clear, hour bit 5 is a PM flag and bits 4:0 hold BCD 01 to 12. 11 steps to 12 and toggles PM, 12 steps to 01 and keeps PM, and the day advances only on the step from 11 PM to 12 AM.
- R8: The day wraps to 01 after 28 in February (month 02) with the leap flag clear, after 29 with it set, after 30 in months 04, 06, 09 and 11, and after 31 in all other months.
- R9: The weekday counts 0 to 6, advances with every day carry, and wraps from 6 to 0.
- R10: Month 12 wraps to 01 and carries into the year; year 99 wraps to 00; the counter never changes the leap flag.
- R11: Address map: 0 is control (bit 0 selects 24-hour), 1 seconds, 2 minutes, 3 hour, 4 weekday, 5 day, 6 month, 7 year (BCD in bits 7:0, leap flag in bit 15), 8 update (commit bit 15). Reads of 1 to 7 return the running field zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 32768 Hz clock-enable pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | 16 | Read data, combinational from rd_addr |

## Verification
A wrong carry decision shows at the ports on the first second tick after the boundary, because a field reads a non-BCD value or misses its wrap. Each boundary is therefore loaded one second before its rollover, and all affected fields are read right after a single tick. Errors in the prescaler or the commit path show up as an off-by-one in the seconds field. The bench counts exact numbers of enable pulses on each side of a commit to expose them. A leap flag corrupted by the counter would only show at the next February rollover, so it is read back after a year wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_W  = 16;
  localparam int A_CTRL = 0;
  localparam int A_SEC  = 1;
  localparam int A_MIN  = 2;
  localparam int A_HOUR = 3;
  localparam int A_WDAY = 4;
  localparam int A_DAY  = 5;
  localparam int A_MON  = 6;
  localparam int A_YEAR = 7;
  localparam int A_UPD  = 8;
  localparam int FLAG_BIT = 15;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] wday;
    logic [5:0] day;
    logic [4:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{sec: 7'h00, min: 7'h00, hour: 6'h00,
                                     wday: 3'd0, day: 6'h01, mon: 5'h01,
                                     year: 8'h00};

  // Increment a two-digit BCD value by one.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  // Last valid day of the month, in BCD.
  function automatic logic [5:0] month_last_day(input logic [4:0] mon,
                                                input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  // True when the hour field is at the last hour of the day.
  function automatic logic hour_is_last(input logic [5:0] h, input logic mode24);
    return mode24 ? (h == 6'h23) : (h == 6'h31);
  endfunction

  // Next hour value; 12-hour format keeps PM in bit 5.
  function automatic logic [5:0] hour_next(input logic [5:0] h, input logic mode24);
    logic [7:0] t;
    t = bcd_inc({3'b000, h[4:0]});
    if (mode24) begin
      if (h == 6'h23) return 6'h00;
      t = bcd_inc({2'b00, h});
      return t[5:0];
    end
    if (h[4:0] == 5'h12) return {h[5], 5'h01};
    if (h[4:0] == 5'h11) return {~h[5], 5'h12};
    return {h[5], t[4:0]};
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic clear,
  output logic sec_pulse
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last   = (cnt_q == LAST);
  assign sec_pulse = tick_en && at_last && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (tick_en) cnt_q <= at_last ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  input  logic      leap,
  input  logic      mode24,
  output rtc_time_t nxt,
  output logic      day_end
);
  logic       sec_wrap, min_wrap, day_step, mon_wrap;
  logic [5:0] last_day;
  logic [7:0] t_sec, t_min, t_day, t_mon, t_year;

  always_comb begin
    t_sec  = bcd_inc({1'b0, cur.sec});
    t_min  = bcd_inc({1'b0, cur.min});
    t_day  = bcd_inc({2'b00, cur.day});
    t_mon  = bcd_inc({3'b000, cur.mon});
    t_year = bcd_inc(cur.year);

    last_day = month_last_day(cur.mon, leap);
    sec_wrap = (cur.sec >= 7'h59);
    min_wrap = sec_wrap && (cur.min >= 7'h59);
    day_step = min_wrap && hour_is_last(cur.hour, mode24);
    day_end  = day_step && (cur.day >= last_day);
    mon_wrap = day_end && (cur.mon >= 5'h12);

    nxt      = cur;
    nxt.sec  = sec_wrap ? 7'h00 : t_sec[6:0];
    if (sec_wrap) nxt.min  = (cur.min >= 7'h59) ? 7'h00 : t_min[6:0];
    if (min_wrap) nxt.hour = hour_next(cur.hour, mode24);
    if (day_step) begin
      nxt.day  = day_end ? 6'h01 : t_day[5:0];
      nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
    end
    if (day_end)  nxt.mon  = mon_wrap ? 5'h01 : t_mon[4:0];
    if (mon_wrap) nxt.year = (cur.year >= 8'h99) ? 8'h00 : t_year;
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data
);
  rtc_time_t now_q, stage_q, now_nxt;
  logic      leap_q, leap_stage_q, mode24_q, trig_q;
  logic      commit, sec_pulse, day_end;

  function automatic logic wr_hit(input int a);
    return wr_en && (wr_addr == ADDR_W'(a));
  endfunction

  assign commit = trig_q;

  rtc_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .clear(commit), .sec_pulse(sec_pulse)
  );

  rtc_advance u_adv (
    .cur(now_q), .leap(leap_q), .mode24(mode24_q),
    .nxt(now_nxt), .day_end(day_end)
  );

  // Control, staged fields and update trigger
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q      <= TIME_RST;
      leap_stage_q <= 1'b0;
      mode24_q     <= 1'b1;
      trig_q       <= 1'b0;
    end else begin
      trig_q <= wr_hit(A_UPD) && wr_data[FLAG_BIT];
      if (wr_hit(A_CTRL)) mode24_q     <= wr_data[0];
      if (wr_hit(A_SEC))  stage_q.sec  <= wr_data[6:0];
      if (wr_hit(A_MIN))  stage_q.min  <= wr_data[6:0];
      if (wr_hit(A_HOUR)) stage_q.hour <= wr_data[5:0];
      if (wr_hit(A_WDAY)) stage_q.wday <= wr_data[2:0];
      if (wr_hit(A_DAY))  stage_q.day  <= wr_data[5:0];
      if (wr_hit(A_MON))  stage_q.mon  <= wr_data[4:0];
      if (wr_hit(A_YEAR)) begin
        stage_q.year <= wr_data[7:0];
        leap_stage_q <= wr_data[FLAG_BIT];
      end
    end
  end

  // Running time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q  <= TIME_RST;
      leap_q <= 1'b0;
    end else if (commit) begin
      now_q  <= stage_q;
      leap_q <= leap_stage_q;
    end else if (sec_pulse) begin
      now_q  <= now_nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_CTRL): rd_data[0]   = mode24_q;
      ADDR_W'(A_SEC):  rd_data[6:0] = now_q.sec;
      ADDR_W'(A_MIN):  rd_data[6:0] = now_q.min;
      ADDR_W'(A_HOUR): rd_data[5:0] = now_q.hour;
      ADDR_W'(A_WDAY): rd_data[2:0] = now_q.wday;
      ADDR_W'(A_DAY):  rd_data[5:0] = now_q.day;
      ADDR_W'(A_MON):  rd_data[4:0] = now_q.mon;
      ADDR_W'(A_YEAR): rd_data      = {leap_q, 7'b0, now_q.year};
      ADDR_W'(A_UPD):  rd_data[FLAG_BIT] = trig_q;
      default:         rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tick_en,
  input logic      commit,
  input logic      sec_pulse,
  input logic      day_end,
  input logic      mode24,
  input logic      leap,
  input rtc_time_t now_t,
  input rtc_time_t stage_t
);
  assert_commit_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> now_t == $past(stage_t));

  assert_pulse_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> tick_en);

  assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !sec_pulse) |=> $stable(now_t));

  assert_sec_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && now_t.sec == 7'h59) |=> now_t.sec == 7'h00);

  assert_hour24_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && mode24 && now_t.hour == 6'h23 && now_t.min == 7'h59
     && now_t.sec == 7'h59) |=> now_t.hour == 6'h00);

  assert_day_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && day_end) |=> now_t.day == 6'h01);

  assert_leap_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(leap));
endmodule

bind bcd_rtc_core rtc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .commit(commit),
  .sec_pulse(sec_pulse), .day_end(day_end), .mode24(mode24_q),
  .leap(leap_q), .now_t(now_q), .stage_t(stage_q)
);

// File: tb/tb_bcd_rtc_core.sv
`timescale 1ns/1ps
module tb_bcd_rtc_core;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [3:0]  q_addr[$];
  logic [15:0] q_exp[$];
  string       q_tag[$];

  bcd_rtc_core #(.PRESCALE(P), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  // Monitor: pops expected items, reads the register, compares.
  initial begin
    forever begin
      wait (q_addr.size() > 0);
      rd_addr = q_addr[0];
      #1;
      checks++;
      if (rd_data !== q_exp[0]) begin
        errors++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", q_tag[0], q_addr[0], rd_data, q_exp[0]);
      end
      void'(q_addr.pop_front());
      void'(q_exp.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic expect_reg(input logic [3:0] a, input logic [15:0] e, input string tag);
    q_addr.push_back(a);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    wait (q_addr.size() == 0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic load(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                      input logic [2:0] w, input logic [5:0] d, input logic [4:0] mo,
                      input logic [7:0] y, input logic lp);
    wr(4'd1, {9'b0, s});
    wr(4'd2, {9'b0, m});
    wr(4'd3, {10'b0, h});
    wr(4'd4, {13'b0, w});
    wr(4'd5, {10'b0, d});
    wr(4'd6, {11'b0, mo});
    wr(4'd7, {lp, 7'b0, y});
    wr(4'd8, 16'h8000);
    @(negedge clk);
  endtask

  task automatic expect_date(input logic [5:0] d, input logic [4:0] mo, input string tag);
    expect_reg(4'd5, {10'b0, d}, tag);
    expect_reg(4'd6, {11'b0, mo}, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R11 reset values and address map
    expect_reg(4'd0, 16'h0001, "R1 ctrl");
    expect_reg(4'd1, 16'h0000, "R1 sec");
    expect_reg(4'd2, 16'h0000, "R1 min");
    expect_reg(4'd3, 16'h0000, "R1 hour");
    expect_reg(4'd4, 16'h0000, "R1 wday");
    expect_reg(4'd5, 16'h0001, "R1 day");
    expect_reg(4'd6, 16'h0001, "R1 mon");
    expect_reg(4'd7, 16'h0000, "R1 year");
    expect_reg(4'd8, 16'h0000, "R1 upd");

    // R2 staged write has no effect before commit
    wr(4'd1, 16'h0030);
    wr(4'd7, 16'h8042);
    expect_reg(4'd1, 16'h0000, "R2 sec staged only");
    expect_reg(4'd7, 16'h0000, "R2 year staged only");

    // R3 trigger visible for one cycle, then all fields committed
    wr(4'd8, 16'h8000);
    expect_reg(4'd8, 16'h8000, "R3 trigger set");
    @(negedge clk);
    expect_reg(4'd8, 16'h0000, "R3 trigger cleared");
    expect_reg(4'd1, 16'h0030, "R3 sec committed");
    expect_reg(4'd7, 16'h8042, "R3 year and leap committed");

    // R4 no advance without enable; exact prescale count; R5/R6/R9/R10 roll
    load(7'h58, 7'h59, 6'h23, 3'd6, 6'h31, 5'h12, 8'h99, 1'b1);
    repeat (10) @(negedge clk);
    expect_reg(4'd1, 16'h0058, "R4 idle without tick_en");
    pulses(P - 1);
    expect_reg(4'd1, 16'h0058, "R4 one short of a second");
    pulses(1);
    expect_reg(4'd1, 16'h0059, "R4 one second");
    pulses(P);
    expect_reg(4'd1, 16'h0000, "R5 sec wrap");
    expect_reg(4'd2, 16'h0000, "R5 min wrap");
    expect_reg(4'd3, 16'h0000, "R6 hour 23 to 00");
    expect_reg(4'd4, 16'h0000, "R9 weekday 6 to 0");
    expect_date(6'h01, 5'h01, "R10 month wrap");
    expect_reg(4'd7, 16'h8000, "R10 year 99 to 00 leap kept");

    // R4 commit restarts the prescaler
    pulses(2);
    load(7'h10, 7'h00, 6'h05, 3'd2, 6'h10, 5'h07, 8'h20, 1'b0);
    pulses(P - 1);
    expect_reg(4'd1, 16'h0010, "R4 prescaler cleared by commit");
    pulses(1);
    expect_reg(4'd1, 16'h0011, "R4 second after commit");
    expect_reg(4'd4, 16'h0002, "R9 weekday held mid-day");

    // R8 month lengths
    load(7'h59, 7'h59, 6'h23, 3'd1, 6'h28, 5'h02, 8'h23, 1'b0);
    pulses(P);
    expect_date(6'h01, 5'h03, "R8 Feb 28 no leap");
    expect_reg(4'd4, 16'h0002, "R9 weekday step");
    load(7'h59, 7'h59, 6'h23, 3'd1, 6'h28, 5'h02, 8'h24, 1'b1);
    pulses(P);
    expect_date(6'h29, 5'h02, "R8 Feb 28 leap");
    load(7'h59, 7'h59, 6'h23, 3'd1, 6'h29, 5'h02, 8'h24, 1'b1);
    pulses(P);
    expect_date(6'h01, 5'h03, "R8 Feb 29 leap");
    load(7'h59, 7'h59, 6'h23, 3'd1, 6'h30, 5'h11, 8'h24, 1'b0);
    pulses(P);
    expect_date(6'h01, 5'h12, "R8 Nov 30");
    load(7'h59, 7'h59, 6'h23, 3'd1, 6'h30, 5'h01, 8'h24, 1'b0);
    pulses(P);
    expect_date(6'h31, 5'h01, "R8 Jan 30");
    load(7'h59, 7'h59, 6'h23, 3'd1, 6'h09, 5'h08, 8'h24, 1'b0);
    pulses(P);
    expect_date(6'h10, 5'h08, "R8 BCD digit carry in day");

    // R7 12-hour format
    wr(4'd0, 16'h0000);
    expect_reg(4'd0, 16'h0000, "R7 ctrl 12h");
    load(7'h59, 7'h59, 6'h11, 3'd3, 6'h05, 5'h03, 8'h24, 1'b0);
    pulses(P);
    expect_reg(4'd3, 16'h0032, "R7 11AM to 12PM");
    expect_reg(4'd5, 16'h0005, "R7 no day step at noon");
    load(7'h59, 7'h59, 6'h31, 3'd3, 6'h05, 5'h03, 8'h24, 1'b0);
    pulses(P);
    expect_reg(4'd3, 16'h0012, "R7 11PM to 12AM");
    expect_reg(4'd5, 16'h0006, "R7 day step at midnight");
    expect_reg(4'd4, 16'h0004, "R7 weekday step at midnight");
    load(7'h59, 7'h59, 6'h32, 3'd3, 6'h05, 5'h03, 8'h24, 1'b0);
    pulses(P);
    expect_reg(4'd3, 16'h0021, "R7 12PM to 1PM");
    wr(4'd0, 16'h0001);
    load(7'h59, 7'h59, 6'h09, 3'd0, 6'h05, 5'h03, 8'h24, 1'b0);
    pulses(P);
    expect_reg(4'd3, 16'h0010, "R6 hour BCD carry 09 to 10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule